// File: doc/BRIEF.md
# Pipeline Hazard Controller

This block is the control plane of a scalar, in-order pipeline with five stages. The stages are fetch (F), decode (D), register read (R), execute (E) and writeback (W). It keeps a slot for each stage, plus one retired slot (X) for the instruction that left writeback on the previous cycle. Each slot holds the decoded fields of the instruction in that stage. A new instruction's fields enter at fetch whenever the controller accepts it. The datapath runs beside the block and follows its strobes: the per-stage valid bits, the holds, the squash and the operand-bypass selects for execute.

Three timing effects are handled:
- **Divide.** A divide sits in execute for `DIV_LAT` cycles. While it does, everything younger is frozen and bubbles drain toward writeback.
- **Taken branch.** A taken branch is resolved in execute. It clears the three younger stages and drops the fetch offered on that cycle, so the environment can present the target next.
- **Read-after-write.** With the bypass enabled, a dependent instruction reads its operand from the writeback slot or the retired slot and never stalls. With the bypass disabled, it waits in register read until the register file holds the value.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, every stage becomes empty. Afterwards, with no input activity: `vld_o` and `stall_o` are all zero, `squash_o` and `rf_we_o` are 0, both selects are 00, and `take_o` is 1.
- R2: With no hazard, an accepted instruction moves exactly one stage per cycle: F, D, R, E, W. `vld_o` bit 0 is F, bit 1 is D, bit 2 is R, bit 3 is E and bit 4 is W. `take_o` is high whenever no stall and no squash is present.
- R3: A divide stays in execute for `DIV_LAT` (6) consecutive cycles. During each cycle except the last, `stall_o` is all ones (bit 0 F, bit 1 D, bit 2 R, bit 3 E) and `take_o` is 0. The stage after execute receives a bubble on each of those cycles.
- R4: When `ex_taken` is high and execute holds a valid branch, `squash_o` is 1 and `take_o` is 0 in that cycle. On the next cycle F, D and R are empty and the branch is in W.
- R5: With `fwd_en` = 1, an execute source equal to the destination of the valid, writing instruction in W gives select 01. A read-after-write never stalls in this mode.
- R6: If the writeback slot does not match but the retired slot does (valid, writing, equal destination), the select is 10. When both match, 01 wins. Code 11 never appears.
- R7: Register 0, a producer with write-enable clear, and an empty slot never cause a forward or a stall. The select is then 00.
- R8: With `fwd_en` = 0, R, D and F hold while a valid writer in E or W has a destination equal to a nonzero source of R. Execute gets a bubble on each such cycle, and both selects stay 00. A back-to-back dependency costs two stall cycles, and a gap of one instruction costs one.
- R9: A squash overrides a read-after-write stall raised in the same cycle. `stall_o` is then 0.
- R10: `rf_we_o` is 1 exactly when W holds a valid instruction with write-enable set and a nonzero destination. `rf_waddr_o` then equals that destination.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fwd_en | input | 1 | 1 enables the execute bypass |
| in_valid | input | 1 | Fetch offers an instruction |
| in_wen | input | 1 | Offered instruction writes a register |
| in_rd | input | 5 | Offered destination register |
| in_rs1 | input | 5 | Offered first source register |
| in_rs2 | input | 5 | Offered second source register |
| in_div | input | 1 | Offered instruction is a divide |
| in_br | input | 1 | Offered instruction is a branch |
| ex_taken | input | 1 | Branch in execute resolved taken |
| take_o | output | 1 | Offered instruction is accepted this cycle |
| vld_o | output | 5 | Valid per stage, bit 0 F through bit 4 W |
| stall_o | output | 4 | Hold per stage, bit 0 F through bit 3 E |
| squash_o | output | 1 | Clear F, D, R and redirect fetch |
| fwd_a_o | output | 2 | Execute operand A select: 00 file, 01 W, 10 retired |
| fwd_b_o | output | 2 | Execute operand B select, same coding |
| rf_we_o | output | 1 | Register file write strobe |
| rf_waddr_o | output | 5 | Register file write address |

## Verification
The hardest situation to reach is a taken branch in execute at the same moment its own result is needed by the instruction in register read, with the bypass off. That cycle raises a read-after-write stall and a squash together. The stimulus gets there with a branch that also writes a link register, followed directly by a reader of that register. A second hard case is a source that matches both the writeback slot and the retired slot at once. Two consecutive writers of one register, followed by a reader, create it. A behavioural model of the stage occupancy predicts every strobe on every cycle. Directed tallies confirm the exact stall counts for a divide and for the two dependency distances.

// File: rtl/hzc_pkg.sv
// Shared types for the pipeline hazard controller.
// Assumes: one register number width for every field.
package hzc_pkg;
    localparam int REG_W = 5;

    typedef logic [REG_W-1:0] reg_idx_t;

    // Decoded control fields carried by one pipeline slot.
    typedef struct packed {
        logic     v;
        logic     we;
        reg_idx_t rd;
        reg_idx_t rs1;
        reg_idx_t rs2;
        logic     div;
        logic     br;
    } hz_slot_t;

    // Operand source for execute.
    typedef enum logic [1:0] {
        SEL_RF  = 2'b00,
        SEL_WB  = 2'b01,
        SEL_RET = 2'b10
    } hz_sel_e;

    // True when a slot will produce a value for register r.
    function automatic logic slot_writes(hz_slot_t s, reg_idx_t r);
        return s.v && s.we && (s.rd != '0) && (s.rd == r);
    endfunction
endpackage

// File: rtl/hzc_div_timer.sv
// Counts the cycles a divide has spent in execute and requests a hold until
// the last one. Assumes: DIV_LAT >= 2, and the execute slot changes only
// when hold is low.
module hzc_div_timer #(
    parameter int DIV_LAT = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ex_is_div,
    output logic hold
);
    localparam int CW = $clog2(DIV_LAT + 1);
    localparam logic [CW-1:0] LAST = CW'(DIV_LAT - 1);

    logic [CW-1:0] cnt;

    // Hold while the divide has not reached its final cycle.
    assign hold = ex_is_div && (cnt != LAST);

    // Advance while holding, restart when execute takes a new slot.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (hold)  cnt <= cnt + 1'b1;
        else            cnt <= '0;
    end

    // R3
    div_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
    // R3
    div_hold_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> ex_is_div);
endmodule

// File: rtl/hzc_fwd_pick.sv
// Chooses the source of one execute operand. The writeback slot has
// priority over the retired slot. Assumes: the register file serves every
// other case.
module hzc_fwd_pick
    import hzc_pkg::*;
(
    input  logic     en,
    input  logic     ex_v,
    input  reg_idx_t src,
    input  hz_slot_t wb,
    input  hz_slot_t ret,
    output hz_sel_e  sel
);
    // Priority pick among the two producer slots.
    always_comb begin
        sel = SEL_RF;
        if (en && ex_v && (src != '0)) begin
            if (slot_writes(wb, src))       sel = SEL_WB;
            else if (slot_writes(ret, src)) sel = SEL_RET;
        end
    end
endmodule

// File: rtl/hzc_slot_pipe.sv
// Six slots of decoded control fields: F, D, R, E, W and retired X.
// Assumes: squash and hold_front never rise with hold_ex on an empty
// execute; squash wins over the front hold.
module hzc_slot_pipe
    import hzc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  hz_slot_t new_slot,
    input  logic     hold_front,
    input  logic     hold_ex,
    input  logic     bub_ex,
    input  logic     squash,
    output hz_slot_t f_q,
    output hz_slot_t d_q,
    output hz_slot_t r_q,
    output hz_slot_t e_q,
    output hz_slot_t w_q,
    output hz_slot_t x_q
);
    // Front stages: cleared by squash, frozen by hold, else shifted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q <= '0;
            d_q <= '0;
            r_q <= '0;
        end else if (squash) begin
            f_q <= '0;
            d_q <= '0;
            r_q <= '0;
        end else if (!hold_front) begin
            f_q <= new_slot;
            d_q <= f_q;
            r_q <= d_q;
        end
    end

    // Back stages: execute may hold or take a bubble; W and X always move.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_q <= '0;
            w_q <= '0;
            x_q <= '0;
        end else begin
            x_q <= w_q;
            if (hold_ex) begin
                w_q <= '0;
            end else begin
                w_q <= e_q;
                e_q <= (squash || bub_ex) ? '0 : r_q;
            end
        end
    end

    // R4
    squash_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        squash |=> (!f_q.v && !d_q.v && !r_q.v));
    // R3
    ex_hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ex |=> ($stable(e_q) && !w_q.v));
    // R2
    retire_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        w_q.v |=> x_q.v);
endmodule

// File: rtl/pipe_hazard_ctrl.sv
// Hazard controller for a five-stage in-order pipeline. It tracks the
// decoded fields per stage and drives holds, squash, bypass selects and the
// register-file write strobe. Assumes: ex_taken is meaningful only when
// execute holds a branch; register reads happen every cycle in R.
module pipe_hazard_ctrl
    import hzc_pkg::*;
#(
    parameter int DIV_LAT = 6,
    parameter int NSRC    = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fwd_en,
    input  logic       in_valid,
    input  logic       in_wen,
    input  logic [4:0] in_rd,
    input  logic [4:0] in_rs1,
    input  logic [4:0] in_rs2,
    input  logic       in_div,
    input  logic       in_br,
    input  logic       ex_taken,
    output logic       take_o,
    output logic [4:0] vld_o,
    output logic [3:0] stall_o,
    output logic       squash_o,
    output logic [1:0] fwd_a_o,
    output logic [1:0] fwd_b_o,
    output logic       rf_we_o,
    output logic [4:0] rf_waddr_o
);
    hz_slot_t new_slot, f_q, d_q, r_q, e_q, w_q, x_q;
    logic     div_hold, raw_stall, squash, stall_front;
    reg_idx_t r_src [NSRC];
    reg_idx_t e_src [NSRC];
    logic [NSRC-1:0] r_hit;
    hz_sel_e  sel [NSRC];

    // Pack the offered instruction into a slot.
    always_comb begin
        new_slot     = '0;
        new_slot.v   = in_valid;
        new_slot.we  = in_wen;
        new_slot.rd  = in_rd;
        new_slot.rs1 = in_rs1;
        new_slot.rs2 = in_rs2;
        new_slot.div = in_div;
        new_slot.br  = in_br;
    end

    // Source register lists of the read and execute stages.
    always_comb begin
        r_src[0] = r_q.rs1;
        r_src[1] = r_q.rs2;
        e_src[0] = e_q.rs1;
        e_src[1] = e_q.rs2;
    end

    hzc_div_timer #(.DIV_LAT(DIV_LAT)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .ex_is_div (e_q.v && e_q.div),
        .hold      (div_hold)
    );

    // One producer compare and one bypass picker per source operand.
    for (genvar s = 0; s < NSRC; s++) begin : g_src
        assign r_hit[s] = slot_writes(e_q, r_src[s]) || slot_writes(w_q, r_src[s]);

        hzc_fwd_pick u_pick (
            .en   (fwd_en),
            .ex_v (e_q.v),
            .src  (e_src[s]),
            .wb   (w_q),
            .ret  (x_q),
            .sel  (sel[s])
        );
    end

    // Without the bypass, R waits until no older writer is still in flight.
    assign raw_stall   = !fwd_en && r_q.v && (|r_hit);
    assign squash      = e_q.v && e_q.br && ex_taken;
    assign stall_front = !squash && (div_hold || raw_stall);

    hzc_slot_pipe u_pipe (
        .clk        (clk),
        .rst_n      (rst_n),
        .new_slot   (new_slot),
        .hold_front (stall_front),
        .hold_ex    (div_hold),
        .bub_ex     (raw_stall),
        .squash     (squash),
        .f_q        (f_q),
        .d_q        (d_q),
        .r_q        (r_q),
        .e_q        (e_q),
        .w_q        (w_q),
        .x_q        (x_q)
    );

    // Control strobes toward the datapath.
    assign take_o     = !squash && !stall_front;
    assign vld_o      = {w_q.v, e_q.v, r_q.v, d_q.v, f_q.v};
    assign stall_o    = {div_hold, stall_front, stall_front, stall_front};
    assign squash_o   = squash;
    assign fwd_a_o    = sel[0];
    assign fwd_b_o    = sel[1];
    assign rf_we_o    = w_q.v && w_q.we && (w_q.rd != '0);
    assign rf_waddr_o = rf_we_o ? w_q.rd : '0;

    // R8
    raw_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_o[2] && !stall_o[3]) |=> !vld_o[3]);
    // R9
    squash_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        squash_o |-> (!take_o && stall_o == 4'b0000));
    // R6
    sel_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_a_o != 2'b11) && (fwd_b_o != 2'b11));
    // R10
    rf_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we_o |-> (rf_waddr_o != 5'd0));
    // R5
    fwd_no_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_en && !stall_o[3]) |-> !stall_o[2]);
endmodule

// File: tb/pipe_hazard_ctrl_test.sv
// Bench: a behavioural occupancy model predicts every strobe each cycle.
module pipe_hazard_ctrl_test;
    localparam int DIVL = 6;

    logic clk = 0, rst_n = 0, fwd_en = 1;
    logic in_valid = 0, in_wen = 0, in_div = 0, in_br = 0, ex_taken = 0;
    logic [4:0] in_rd = 0, in_rs1 = 0, in_rs2 = 0;
    logic take_o, squash_o, rf_we_o;
    logic [4:0] vld_o, rf_waddr_o;
    logic [3:0] stall_o;
    logic [1:0] fwd_a_o, fwd_b_o;

    always #5 clk = ~clk;

    pipe_hazard_ctrl uut (
        .clk(clk), .rst_n(rst_n), .fwd_en(fwd_en), .in_valid(in_valid),
        .in_wen(in_wen), .in_rd(in_rd), .in_rs1(in_rs1), .in_rs2(in_rs2),
        .in_div(in_div), .in_br(in_br), .ex_taken(ex_taken), .take_o(take_o),
        .vld_o(vld_o), .stall_o(stall_o), .squash_o(squash_o),
        .fwd_a_o(fwd_a_o), .fwd_b_o(fwd_b_o), .rf_we_o(rf_we_o),
        .rf_waddr_o(rf_waddr_o)
    );

    int checks = 0, fails = 0;
    logic       p_we [32], p_div [32], p_br [32], p_tk [32];
    logic [4:0] p_rd [32], p_rs1 [32], p_rs2 [32];
    int         p_tgt [32];
    int plen, pc, divcnt;
    int st [6];
    int cnt_hold, cnt_front, cnt_ret;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic add(logic we, logic [4:0] rd, logic [4:0] a, logic [4:0] b,
                       logic dv, logic br, logic tk, int tgt);
        p_we[plen] = we; p_rd[plen] = rd; p_rs1[plen] = a; p_rs2[plen] = b;
        p_div[plen] = dv; p_br[plen] = br; p_tk[plen] = tk; p_tgt[plen] = tgt;
        plen++;
    endtask

    function automatic bit wr(int idx, logic [4:0] r);
        return idx >= 0 && p_we[idx] && p_rd[idx] != 0 && p_rd[idx] == r;
    endfunction

    function automatic int exp_sel(logic [4:0] r);
        if (!fwd_en || st[3] < 0 || r == 0) return 0;
        if (wr(st[4], r)) return 1;
        if (wr(st[5], r)) return 2;
        return 0;
    endfunction

    // Reset, then R1 checks on the idle outputs.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; in_valid = 0; ex_taken = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1 vld", vld_o, 0);
        chk("R1 stall", stall_o, 0);
        chk("R1 squash", squash_o, 0);
        chk("R1 take", take_o, 1);
        chk("R1 sel", {fwd_a_o, fwd_b_o}, 0);
        chk("R1 rfwe", rf_we_o, 0);
        rst_n = 1;
        for (int i = 0; i < 6; i++) st[i] = -1;
        pc = 0; divcnt = 0; cnt_hold = 0; cnt_front = 0; cnt_ret = 0;
    endtask

    task automatic run(int ncyc);
        int ns [6];
        bit hold, sq, raw, stl;
        for (int c = 0; c < ncyc; c++) begin
            if (c > 0) @(negedge clk);
            ex_taken = st[3] >= 0 && p_br[st[3]] && p_tk[st[3]];
            in_valid = pc < plen;
            if (pc < plen) begin
                in_wen = p_we[pc]; in_rd = p_rd[pc]; in_rs1 = p_rs1[pc];
                in_rs2 = p_rs2[pc]; in_div = p_div[pc]; in_br = p_br[pc];
            end else begin
                in_wen = 0; in_rd = 0; in_rs1 = 0; in_rs2 = 0; in_div = 0; in_br = 0;
            end
            #1;
            hold = st[3] >= 0 && p_div[st[3]] && divcnt < DIVL - 1;
            sq = ex_taken;
            raw = 0;
            if (!fwd_en && st[2] >= 0)
                for (int k = 3; k < 5; k++)
                    if (wr(st[k], p_rs1[st[2]]) || wr(st[k], p_rs2[st[2]])) raw = 1;
            stl = !sq && (hold || raw);
            chk("R2 vld", vld_o, {st[4] >= 0, st[3] >= 0, st[2] >= 0, st[1] >= 0, st[0] >= 0});
            chk("R3 R8 stall", stall_o, {hold, stl, stl, stl});
            chk("R4 R9 squash", squash_o, sq);
            chk("R2 R4 take", take_o, !stl && !sq);
            chk("R5 R6 R7 sel_a", fwd_a_o, st[3] >= 0 ? exp_sel(p_rs1[st[3]]) : 0);
            chk("R5 R6 R7 sel_b", fwd_b_o, st[3] >= 0 ? exp_sel(p_rs2[st[3]]) : 0);
            chk("R10 rf_we", rf_we_o, st[4] >= 0 && p_we[st[4]] && p_rd[st[4]] != 0);
            if (rf_we_o) chk("R10 rf_addr", rf_waddr_o, p_rd[st[4]]);
            if (stall_o[3]) cnt_hold++;
            if (stall_o[2]) cnt_front++;
            if (fwd_a_o == 2'b10 || fwd_b_o == 2'b10) cnt_ret++;
            ns[5] = st[4];
            ns[4] = hold ? -1 : st[3];
            ns[3] = hold ? st[3] : (sq || raw) ? -1 : st[2];
            ns[2] = sq ? -1 : stl ? st[2] : st[1];
            ns[1] = sq ? -1 : stl ? st[1] : st[0];
            ns[0] = sq ? -1 : stl ? st[0] : (pc < plen ? pc : -1);
            divcnt = hold ? divcnt + 1 : 0;
            if (sq) pc = p_tgt[st[3]];
            else if (!stl && pc < plen) pc++;
            @(posedge clk);
            for (int i = 0; i < 6; i++) st[i] = ns[i];
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        // Bypass chains, double match, r0 and no-write producers (R5 R6 R7).
        fwd_en = 1; plen = 0;
        add(1, 1, 0, 0, 0, 0, 0, 0);
        add(1, 2, 1, 0, 0, 0, 0, 0);
        add(1, 4, 0, 1, 0, 0, 0, 0);
        add(1, 3, 0, 0, 0, 0, 0, 0);
        add(1, 3, 0, 0, 0, 0, 0, 0);
        add(0, 0, 3, 2, 0, 0, 0, 0);
        add(1, 0, 0, 0, 0, 0, 0, 0);
        add(0, 7, 0, 0, 0, 0, 0, 0);
        add(0, 0, 0, 7, 0, 0, 0, 0);
        do_reset(); run(30);
        chk("R6 retired select seen", cnt_ret > 0, 1);
        chk("R5 no stall with bypass", cnt_front, 0);

        // Divide holds execute (R3).
        plen = 0;
        add(1, 5, 1, 2, 1, 0, 0, 0);
        add(1, 6, 5, 0, 0, 0, 0, 0);
        add(1, 7, 0, 6, 0, 0, 0, 0);
        add(0, 0, 0, 0, 0, 0, 0, 0);
        do_reset(); run(30);
        chk("R3 divide hold cycles", cnt_hold, DIVL - 1);

        // Taken and untaken branches (R4).
        plen = 0;
        add(1, 1, 0, 0, 0, 0, 0, 0);
        add(0, 0, 0, 0, 0, 1, 1, 5);
        add(1, 8, 0, 0, 0, 0, 0, 0);
        add(1, 9, 0, 0, 0, 0, 0, 0);
        add(1, 10, 0, 0, 0, 0, 0, 0);
        add(1, 2, 1, 0, 0, 0, 0, 0);
        add(0, 0, 2, 0, 0, 1, 0, 0);
        add(1, 3, 2, 0, 0, 0, 0, 0);
        do_reset(); run(30);

        // No bypass: two stalls back to back, one stall at distance two (R8).
        fwd_en = 0; plen = 0;
        add(1, 1, 0, 0, 0, 0, 0, 0);
        add(1, 2, 1, 0, 0, 0, 0, 0);
        add(0, 0, 0, 0, 0, 0, 0, 0);
        add(0, 0, 0, 2, 0, 0, 0, 0);
        add(0, 0, 0, 0, 0, 0, 0, 0);
        do_reset(); run(30);
        chk("R8 total stall cycles", cnt_front, 3);

        // Squash beats a same-cycle stall (R9).
        plen = 0;
        add(0, 0, 0, 0, 0, 0, 0, 0);
        add(1, 6, 0, 0, 0, 1, 1, 4);
        add(0, 0, 6, 0, 0, 0, 0, 0);
        add(1, 9, 0, 0, 0, 0, 0, 0);
        add(1, 7, 6, 0, 0, 0, 0, 0);
        do_reset(); run(30);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule